// File: doc/BRIEF.md
# Wake-on-LAN event output controller

This block turns packet-classification strobes from a receive path into one wake signal for a power-management controller. A 16-bit configuration register, written and read through a plain register port, selects which frame classes may wake the system: unicast, broadcast, pattern match and magic packet. A master enhanced-receive bit gates all of them, and an optional password check further qualifies magic packets.

A qualifying event drives the registered wake output in one of two ways. In pulse mode the output stays high for a programmable count of cycles. In level mode the output stays high until software writes a self-clearing clear bit. The strobes arrive one cycle wide in the receive clock domain. Frame parsing and detection of these classes happen upstream of this block.

Top module: `wol_wake_ctrl`

## Requirements
- R1: After reset the register reads 0x0004: broadcast wake (bit 2) is set and every other bit is 0.
- R2: Bits 15:12, 6 and 3 always read 0 and ignore writes. The clear bit (bit 11) never reads back as 1.
- R3: Bits 10:7, 5:4 and 2:0 read back the last value written to them.
- R4: While the master enable (bit 7) is 0, no event strobe raises wake_o.
- R5: Each event has its own enable bit: unicast bit 4, broadcast bit 2, pattern bit 1, magic bit 0. An event with its enable clear is ignored.
- R6: With the password bit (bit 5) set, a magic strobe qualifies only when pwd_match_i is high in the same cycle. A password strobe alone never qualifies.
- R7: In pulse mode (bit 8 = 0), wake_o is high for exactly PULSE_BASE<<sel cycles, where sel is bits 10:9. With the default PULSE_BASE this gives 8, 16, 32 or 64 cycles.
- R8: In pulse mode, a qualifying event during an active pulse restarts the full programmed length.
- R9: In level mode (bit 8 = 1), wake_o stays high until a register write with bit 11 set. It is low in the cycle after that write.
- R10: In level mode, a qualifying event in the same cycle as a clear write keeps wake_o high.
- R11: In pulse mode a clear write does not shorten the pulse.
- R12: wake_o is registered. It rises on the first clock edge that samples a qualifying strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data |
| ucast_i | input | 1 | Unicast frame strobe |
| bcast_i | input | 1 | Broadcast frame strobe |
| pattern_i | input | 1 | Pattern match strobe |
| magic_i | input | 1 | Magic packet strobe |
| pwd_match_i | input | 1 | Password match strobe |
| wake_o | output | 1 | Wake output |

## Verification
The bench uses the default PULSE_BASE of 8, so the longest pulse is 64 cycles. This lets every length code be timed exactly, cycle by cycle, within a short run. Because pulses are this short, the retrigger and the pulse-mode clear tests can also land inside a live pulse and measure the whole remaining length. The enable matrix runs in level mode, so each qualified or ignored event leaves a steady output that can be sampled before the next clear.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int unsigned CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_RST    = 16'h0004;
  localparam logic [CFG_W-1:0] CFG_WMASK  = 16'h07B7;
  localparam int unsigned BIT_CLR    = 11;
  localparam int unsigned BIT_LEN    = 9;
  localparam int unsigned BIT_LVL    = 8;
  localparam int unsigned BIT_MASTER = 7;
  localparam int unsigned BIT_PWD    = 5;
  localparam int unsigned BIT_UC     = 4;
  localparam int unsigned BIT_BC     = 2;
  localparam int unsigned BIT_PAT    = 1;
  localparam int unsigned BIT_MAG    = 0;
  localparam int unsigned N_EV       = 4;

  typedef struct packed {
    logic [1:0]      len_sel;
    logic            lvl_mode;
    logic            master;
    logic            pwd_en;
    logic [N_EV-1:0] ev_en;   // {uc, bc, pat, mag}
  } cfg_t;
endpackage

// File: rtl/wol_cfg_reg.sv
module wol_cfg_reg
  import wol_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output logic             clr_o,
  output cfg_t             cfg_o
);
  logic [CFG_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= CFG_RST;
    else if (we_i) reg_q <= wdata_i & CFG_WMASK;
  end

  // clear bit acts in the write cycle and is never stored
  assign clr_o   = we_i & wdata_i[BIT_CLR];
  assign rdata_o = reg_q;

  always_comb begin
    cfg_o.len_sel  = reg_q[BIT_LEN +: 2];
    cfg_o.lvl_mode = reg_q[BIT_LVL];
    cfg_o.master   = reg_q[BIT_MASTER];
    cfg_o.pwd_en   = reg_q[BIT_PWD];
    cfg_o.ev_en    = {reg_q[BIT_UC], reg_q[BIT_BC], reg_q[BIT_PAT], reg_q[BIT_MAG]};
  end
endmodule

// File: rtl/wol_event_qual.sv
module wol_event_qual
  import wol_pkg::*;
(
  input  cfg_t            cfg_i,
  input  logic [N_EV-1:0] ev_i,     // {uc, bc, pat, mag}
  input  logic            pwd_match_i,
  output logic            hit_o
);
  logic [N_EV-1:0] ev_ok;

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    if (g == 0) begin : g_mag
      assign ev_ok[g] = ev_i[g] & cfg_i.ev_en[g] & (~cfg_i.pwd_en | pwd_match_i);
    end else begin : g_plain
      assign ev_ok[g] = ev_i[g] & cfg_i.ev_en[g];
    end
  end

  assign hit_o = cfg_i.master & (|ev_ok);
endmodule

// File: rtl/wol_out_gen.sv
module wol_out_gen #(
  parameter int unsigned PULSE_BASE = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       clr_i,
  input  logic       lvl_mode_i,
  input  logic [1:0] len_sel_i,
  output logic       wake_o
);
  localparam int unsigned MAX_LEN = PULSE_BASE * 8;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN);

  logic [CNT_W-1:0] cnt_q, load_val;
  logic             wake_q;

  assign load_val = CNT_W'((PULSE_BASE << len_sel_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= 1'b0;
      cnt_q  <= '0;
    end else if (lvl_mode_i) begin
      cnt_q <= '0;
      if (hit_i)      wake_q <= 1'b1;   // event beats clear
      else if (clr_i) wake_q <= 1'b0;
    end else if (hit_i) begin
      wake_q <= 1'b1;
      cnt_q  <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      wake_q <= 1'b0;
    end
  end

  assign wake_o = wake_q;

  // R7
  idle_cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_mode_i && !wake_q) |-> (cnt_q == '0));
  // R9
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_mode_i && wake_q && !clr_i) |=> wake_q);
  // R10
  level_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_mode_i && clr_i && !hit_i) |=> !wake_q);
endmodule

// File: rtl/wol_wake_ctrl.sv
module wol_wake_ctrl
  import wol_pkg::*;
#(
  parameter int unsigned PULSE_BASE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             ucast_i,
  input  logic             bcast_i,
  input  logic             pattern_i,
  input  logic             magic_i,
  input  logic             pwd_match_i,
  output logic             wake_o
);
  cfg_t cfg;
  logic clr, hit;

  wol_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .clr_o   (clr),
    .cfg_o   (cfg)
  );

  wol_event_qual u_qual (
    .cfg_i       (cfg),
    .ev_i        ({ucast_i, bcast_i, pattern_i, magic_i}),
    .pwd_match_i (pwd_match_i),
    .hit_o       (hit)
  );

  wol_out_gen #(.PULSE_BASE(PULSE_BASE)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .clr_i      (clr),
    .lvl_mode_i (cfg.lvl_mode),
    .len_sel_i  (cfg.len_sel),
    .wake_o     (wake_o)
  );

  // R12
  rise_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(hit));
  // R4
  master_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[BIT_MASTER] |-> !hit);
endmodule

// File: tb/tb_wol_wake_ctrl.sv
module tb_wol_wake_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        ucast_i = 0, bcast_i = 0, pattern_i = 0, magic_i = 0, pwd_match_i = 0;
  logic        wake_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  wol_wake_ctrl dut (.*);

  // {cfg[15:0], uc, bc, pat, mag, pwd, expect}
  localparam logic [21:0] VEC [10] = '{
    {16'h0184, 5'b01000, 1'b1},   // R5 broadcast enabled
    {16'h0104, 5'b01000, 1'b0},   // R4 master off
    {16'h0184, 5'b10000, 1'b0},   // R5 unicast disabled
    {16'h0190, 5'b10000, 1'b1},   // R5 unicast
    {16'h0182, 5'b00100, 1'b1},   // R5 pattern
    {16'h0181, 5'b00010, 1'b1},   // R5 magic
    {16'h01A1, 5'b00010, 1'b0},   // R6 magic without password
    {16'h01A1, 5'b00011, 1'b1},   // R6 magic with password
    {16'h0180, 5'b11110, 1'b0},   // R5 all disabled
    {16'h01B7, 5'b00001, 1'b0}    // R6 password alone
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic fire(input logic [4:0] ev);
    @(negedge clk_i);
    {ucast_i, bcast_i, pattern_i, magic_i, pwd_match_i} = ev;
    @(negedge clk_i);
    {ucast_i, bcast_i, pattern_i, magic_i, pwd_match_i} = '0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (wake_o && n < 200) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cfg_rdata_o == 16'h0004, "R1", cfg_rdata_o, 16'h0004);
    check(wake_o == 1'b0, "R1", wake_o, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][21:6] | 16'h0800);
      fire(VEC[i][5:1]);
      check(wake_o == VEC[i][0], "R4/R5/R6 vector", wake_o, VEC[i][0]);
      wr(VEC[i][21:6] | 16'h0800);
    end

    // R2 R3 register access
    wr(16'hFFFF);
    check(cfg_rdata_o == 16'h07B7, "R2", cfg_rdata_o, 16'h07B7);
    wr(16'h0000);
    check(cfg_rdata_o == 16'h0000, "R3", cfg_rdata_o, 0);
    wr(16'h0535);
    check(cfg_rdata_o == 16'h0535, "R3", cfg_rdata_o, 16'h0535);

    // R7 pulse lengths
    for (int s = 0; s < 4; s++) begin
      wr(16'h0084 | 16'(s << 9));
      fire(5'b01000);
      count_high(n);
      check(n == (8 << s), "R7", n, 8 << s);
    end

    // R8 retrigger
    wr(16'h0084);
    fire(5'b01000);
    repeat (3) @(negedge clk_i);
    check(wake_o == 1'b1, "R8", wake_o, 1);
    fire(5'b01000);
    count_high(n);
    check(n == 8, "R8", n, 8);

    // R11 clear in pulse mode
    wr(16'h0684);
    fire(5'b01000);
    wr(16'h0E84);
    check(wake_o == 1'b1, "R11", wake_o, 1);
    count_high(n);
    check(n == 62, "R11", n, 62);

    // R12 registered rise, R9 level hold and clear
    wr(16'h0184);
    @(negedge clk_i); bcast_i = 1'b1; #1;
    check(wake_o == 1'b0, "R12", wake_o, 0);
    @(negedge clk_i); bcast_i = 1'b0;
    check(wake_o == 1'b1, "R12", wake_o, 1);
    repeat (20) @(negedge clk_i);
    check(wake_o == 1'b1, "R9", wake_o, 1);
    wr(16'h0984);
    check(wake_o == 1'b0, "R9", wake_o, 0);
    check(cfg_rdata_o == 16'h0184, "R2", cfg_rdata_o, 16'h0184);

    // R10 event beats clear
    fire(5'b01000);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 16'h0984; bcast_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0; bcast_i = 1'b0;
    check(wake_o == 1'b1, "R10", wake_o, 1);
    wr(16'h0984);
    check(wake_o == 1'b0, "R10", wake_o, 0);

    summary();
  end
endmodule